// File: doc/BRIEF.md
# Interrupt Pending/Active State Tracker

This block holds the pending and active state for a bank of physical interrupt lines and raises one request toward the host CPU. Each line is set up on its own as level-sensitive or edge-sensitive. A second configuration bit per line selects a class that has no active state. Raw inputs pass through a synchroniser. Edge lines latch a low-to-high transition of the synchronised input. Level lines follow the synchronised input for as long as they are not in service.

Three indexed strobes change the state. Acknowledge moves a pending line into service. Deactivate ends the service; another agent may drive it on the host's behalf. Set-active marks a line as in service without any acknowledge, so that an interrupt handed on to another consumer is pre-marked and stays silent toward the host. A line in service never requests the host, even while its level input stays high. When a level line is deactivated, its input is sampled again at once. An edge line may be pending and active at the same time.

The request output is the OR of the lines that are pending but not active. The selected ID is the lowest-numbered such line.

Top module: `irq_state_tracker`

## Requirements
- R1: While reset is asserted and after its release, all pending and active bits read 0, and `host_irq` and `sel_valid` are 0.
- R2: With the default two synchroniser stages, a change on `irq_in` driven before clock edge k is visible in `pending_vec` after edge k+2 and not before.
- R3: For a level line (`cfg_edge` bit = 0) that is not active, pending follows the synchronised input. A level line that is active is never pending and never drives `host_irq`, even while its input stays high.
- R4: `ack_valid` with `ack_id` naming a pending line whose `cfg_no_active` bit = 0 sets that line active and clears its pending bit one clock later. Acknowledging a line that is not pending changes nothing.
- R5: `deact_valid` with `deact_id` clears the named line's active bit one clock later. If that line is level-sensitive and its synchronised input is still high, it is pending in the same cycle.
- R6: `set_act_valid` with `set_act_id` marks the named line active one clock later, without any acknowledge.
- R7: For an edge line (`cfg_edge` bit = 1), a synchronised low-to-high transition sets pending, whether or not the line is active. A line that is both pending and active does not request the host.
- R8: For a line whose `cfg_no_active` bit = 1, acknowledge only clears pending. Its active bit stays 0, and set-active has no effect on it.
- R9: `host_irq` is 1 exactly when some line is pending and not active. `sel_valid` equals `host_irq`, and `sel_id` is the lowest index among those lines.
- R10: When set-active and deactivate name the same line in the same cycle, the line ends up active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw interrupt lines |
| cfg_edge | input | NUM_LINES | Per line: 1 = edge-sensitive, 0 = level-sensitive |
| cfg_no_active | input | NUM_LINES | Per line: 1 = class without an active state |
| set_act_valid | input | 1 | Set-active strobe |
| set_act_id | input | IDW | Line addressed by set-active |
| deact_valid | input | 1 | Deactivate strobe |
| deact_id | input | IDW | Line addressed by deactivate |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | IDW | Line addressed by acknowledge |
| host_irq | output | 1 | Request to the host CPU |
| sel_valid | output | 1 | `sel_id` is meaningful |
| sel_id | output | IDW | Lowest pending, non-active line |
| pending_vec | output | NUM_LINES | Pending bits |
| active_vec | output | NUM_LINES | Active bits |

## Verification
An acknowledge, deactivate or set-active strobe driven before a clock edge shows up in `pending_vec` and `active_vec` right after that edge. `host_irq`, `sel_valid` and `sel_id` follow from the registered state in the same cycle. A change on `irq_in` needs two synchroniser edges plus the state edge, so it appears after the third edge. The bench drives every input on the falling edge. It advances its own model by exactly one state update per rising edge and compares at the next falling edge, which places every check in the cycle where the result is due. The directed checks for R2 also sample one cycle early, to show that the input has not yet arrived.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;

   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_EDGE  = 1'b1
   } trig_e;

   localparam int unsigned MAX_LINES = 1024;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= '0;
            end else begin
               stg_q[0] <= d;
               for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
            end
         end
         assign q = stg_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
   import irq_trk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   input  logic cfg_edge,
   input  logic cfg_no_active,
   input  logic set_hit,
   input  logic deact_hit,
   input  logic ack_hit,
   output logic pend_o,
   output logic act_o
);

   trig_e mode;
   logic  prev_q, pend_q, act_q;
   logic  edge_ev, ack_sel, act_d, pend_d;

   assign mode    = cfg_edge ? TRIG_EDGE : TRIG_LEVEL;
   assign edge_ev = sync_in & ~prev_q;
   assign ack_sel = ack_hit & pend_q;

   always_comb begin
      act_d = act_q & ~deact_hit;
      if (set_hit) act_d = 1'b1;
      if (ack_sel) act_d = 1'b1;
      if (cfg_no_active) act_d = 1'b0;
   end

   always_comb begin
      case (mode)
         TRIG_EDGE: pend_d = (pend_q & ~ack_sel) | edge_ev;
         default:   pend_d = sync_in & ~act_d & ~ack_sel;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_q <= 1'b0;
         act_q  <= 1'b0;
      end else begin
         prev_q <= sync_in;
         pend_q <= pend_d;
         act_q  <= act_d;
      end
   end

   assign pend_o = pend_q;
   assign act_o  = act_q;

   p_level_active_mute_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && mode == TRIG_LEVEL && $stable(cfg_edge)) |-> !pend_q);

   p_ack_sets_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && pend_q && !cfg_no_active) |=> act_q);

   p_deact_resample_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRIG_LEVEL && deact_hit && !set_hit && sync_in && !cfg_no_active
       && !(ack_hit && pend_q)) |=> pend_q);

   p_set_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hit && !cfg_no_active) |=> act_q);

   p_edge_sets_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRIG_EDGE && sync_in && !prev_q) |=> pend_q);

   p_no_active_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_hit || (ack_hit && pend_q)) && cfg_no_active) |=> !act_q);

   p_ack_clears_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && pend_q && !(mode == TRIG_EDGE && sync_in && !prev_q)) |=> !pend_q);

   p_set_beats_deact_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hit && deact_hit && !cfg_no_active) |=> act_q);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned N   = 16,
   parameter int unsigned IDW = 4
) (
   input  logic [N-1:0]   req,
   output logic           valid,
   output logic [IDW-1:0] id
);

   always_comb begin
      id = '0;
      for (int i = int'(N) - 1; i >= 0; i--) begin
         if (req[i]) id = IDW'(i);
      end
   end

   assign valid = |req;

endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker #(
   parameter  int unsigned NUM_LINES   = 16,
   parameter  int unsigned SYNC_STAGES = 2,
   localparam int unsigned IDW         = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic [NUM_LINES-1:0] cfg_edge,
   input  logic [NUM_LINES-1:0] cfg_no_active,
   input  logic                 set_act_valid,
   input  logic [IDW-1:0]       set_act_id,
   input  logic                 deact_valid,
   input  logic [IDW-1:0]       deact_id,
   input  logic                 ack_valid,
   input  logic [IDW-1:0]       ack_id,
   output logic                 host_irq,
   output logic                 sel_valid,
   output logic [IDW-1:0]       sel_id,
   output logic [NUM_LINES-1:0] pending_vec,
   output logic [NUM_LINES-1:0] active_vec
);

   generate
      if (NUM_LINES < 2 || NUM_LINES > irq_trk_pkg::MAX_LINES) begin : g_bad_lines
         $error("irq_state_tracker: NUM_LINES out of range");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("irq_state_tracker: SYNC_STAGES above 4");
      end
   endgenerate

   logic [NUM_LINES-1:0] sync_vec;
   logic [NUM_LINES-1:0] req_vec;

   irq_sync #(
      .WIDTH (NUM_LINES),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (irq_in),
      .q    (sync_vec)
   );

   generate
      for (genvar i = 0; i < int'(NUM_LINES); i++) begin : g_line
         logic set_hit, deact_hit, ack_hit;
         assign set_hit   = set_act_valid && (set_act_id == IDW'(i));
         assign deact_hit = deact_valid   && (deact_id   == IDW'(i));
         assign ack_hit   = ack_valid     && (ack_id     == IDW'(i));

         irq_line_cell u_cell (
            .clk          (clk),
            .rst_n        (rst_n),
            .sync_in      (sync_vec[i]),
            .cfg_edge     (cfg_edge[i]),
            .cfg_no_active(cfg_no_active[i]),
            .set_hit      (set_hit),
            .deact_hit    (deact_hit),
            .ack_hit      (ack_hit),
            .pend_o       (pending_vec[i]),
            .act_o        (active_vec[i])
         );
      end
   endgenerate

   assign req_vec  = pending_vec & ~active_vec;
   assign host_irq = |req_vec;

   irq_prio_pick #(
      .N  (NUM_LINES),
      .IDW(IDW)
   ) u_pick (
      .req  (req_vec),
      .valid(sel_valid),
      .id   (sel_id)
   );

   p_sel_is_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid |-> (pending_vec[sel_id] && !active_vec[sel_id]));

   p_sel_matches_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sel_valid == host_irq);

endmodule

// File: tb/irq_state_tracker_tb_top.sv
module irq_state_tracker_tb_top;

   localparam int N   = 16;
   localparam int IDW = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   irq_in = '0, cfg_edge = '0, cfg_no_active = '0;
   logic           set_act_valid = 1'b0, deact_valid = 1'b0, ack_valid = 1'b0;
   logic [IDW-1:0] set_act_id = '0, deact_id = '0, ack_id = '0;
   logic           host_irq, sel_valid;
   logic [IDW-1:0] sel_id;
   logic [N-1:0]   pending_vec, active_vec;

   int n_checks = 0;
   int n_fails  = 0;

   always #2 clk = ~clk;

   irq_state_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_edge(cfg_edge),
      .cfg_no_active(cfg_no_active), .set_act_valid(set_act_valid),
      .set_act_id(set_act_id), .deact_valid(deact_valid), .deact_id(deact_id),
      .ack_valid(ack_valid), .ack_id(ack_id), .host_irq(host_irq),
      .sel_valid(sel_valid), .sel_id(sel_id), .pending_vec(pending_vec),
      .active_vec(active_vec)
   );

   // reference state, built from the requirements
   logic [N-1:0] m_s1 = '0, m_s2 = '0, m_sq = '0, m_pend = '0, m_act = '0;
   logic [N-1:0] n_s1, n_s2, n_sq, n_pend, n_act;

   function automatic logic [IDW:0] lowest(input logic [N-1:0] r);
      for (int i = 0; i < N; i++) if (r[i]) return {1'b1, IDW'(i)};
      return '0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_next();
      logic [N-1:0] setv, deav, ackv, edgev;
      if (!rst_n) begin
         {n_s1, n_s2, n_sq, n_pend, n_act} = '0;
         return;
      end
      setv  = set_act_valid ? (N'(1) << set_act_id) : '0;
      deav  = deact_valid   ? (N'(1) << deact_id)   : '0;
      ackv  = ack_valid     ? ((N'(1) << ack_id) & m_pend) : '0;
      edgev = m_s2 & ~m_sq;
      n_act = ((m_act & ~deav) | setv | ackv) & ~cfg_no_active;          // R4 R6 R8 R10
      n_pend = (cfg_edge & ((m_pend & ~ackv) | edgev))                   // R7
             | (~cfg_edge & m_s2 & ~n_act & ~ackv);                      // R3 R5
      n_s1 = irq_in; n_s2 = m_s1; n_sq = m_s2;                           // R2
   endtask

   task automatic compare_all();
      logic [N-1:0] req;
      logic [IDW:0] pick;
      req  = m_pend & ~m_act;
      pick = lowest(req);
      chk("R3/R7 pending_vec", 32'(pending_vec), 32'(m_pend));
      chk("R4/R6 active_vec", 32'(active_vec), 32'(m_act));
      chk("R9 host_irq", 32'(host_irq), 32'(|req));
      chk("R9 sel_valid", 32'(sel_valid), 32'(pick[IDW]));
      if (pick[IDW]) chk("R9 sel_id", 32'(sel_id), 32'(pick[IDW-1:0]));
   endtask

   // one rising edge: model update, then compare at the falling edge
   task automatic cyc();
      model_next();
      @(negedge clk);
      {m_s1, m_s2, m_sq, m_pend, m_act} = {n_s1, n_s2, n_sq, n_pend, n_act};
      compare_all();
   endtask

   task automatic clear_strobes();
      set_act_valid = 1'b0; deact_valid = 1'b0; ack_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; irq_in = '0; clear_strobes();
      repeat (3) cyc();
      chk("R1 pending in reset", 32'(pending_vec), 0);
      chk("R1 active in reset", 32'(active_vec), 0);
      rst_n = 1'b1;
      cyc();
      chk("R1 host_irq after reset", 32'(host_irq), 0);
   endtask

   task automatic strobe_ack(input int id);
      ack_valid = 1'b1; ack_id = IDW'(id); cyc(); clear_strobes();
   endtask
   task automatic strobe_deact(input int id);
      deact_valid = 1'b1; deact_id = IDW'(id); cyc(); clear_strobes();
   endtask
   task automatic strobe_set(input int id);
      set_act_valid = 1'b1; set_act_id = IDW'(id); cyc(); clear_strobes();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      // directed: lines 4..7 and 9 edge, lines 8 and 9 without active state
      cfg_edge = 16'h02F0; cfg_no_active = 16'h0300;
      do_reset();

      // R2: level line 2 raised, visible after the third edge
      irq_in[2] = 1'b1;
      cyc(); cyc();
      chk("R2 not yet pending", 32'(pending_vec[2]), 0);
      cyc();
      chk("R2 pending after sync", 32'(pending_vec[2]), 1);
      chk("R9 sel_id line 2", 32'(sel_id), 2);

      // R4: acknowledge moves to active; R3: level stays muted
      strobe_ack(2);
      chk("R4 active after ack", 32'(active_vec[2]), 1);
      chk("R4 pending cleared", 32'(pending_vec[2]), 0);
      repeat (5) cyc();
      chk("R3 active level muted", 32'(host_irq), 0);
      chk("R3 no pending while active", 32'(pending_vec[2]), 0);

      // R4: ack on non-pending line has no effect
      strobe_ack(3);
      chk("R4 ack idle line", 32'(active_vec[3]), 0);

      // R5: deactivate with input high resamples at once
      strobe_deact(2);
      chk("R5 active cleared", 32'(active_vec[2]), 0);
      chk("R5 pending resampled", 32'(pending_vec[2]), 1);
      chk("R5 host signalled again", 32'(host_irq), 1);
      strobe_ack(2);
      irq_in[2] = 1'b0;
      repeat (3) cyc();
      strobe_deact(2);
      chk("R5 low input stays idle", 32'(pending_vec[2]), 0);

      // R6: set-active on edge line 5 without ack; R7: edge while active
      strobe_set(5);
      chk("R6 set active", 32'(active_vec[5]), 1);
      irq_in[5] = 1'b1;
      repeat (3) cyc();
      chk("R7 edge while active pends", 32'(pending_vec[5]), 1);
      chk("R7 pending+active kept", 32'(active_vec[5]), 1);
      chk("R7 no request", 32'(host_irq), 0);
      strobe_deact(5);
      chk("R7 delivered after deact", 32'(sel_id), 5);
      strobe_ack(5);
      chk("R7 acked edge idle", 32'(pending_vec[5]), 0);
      strobe_deact(5);

      // R8: no-active edge line 9
      irq_in[9] = 1'b1;
      repeat (3) cyc();
      chk("R8 pending before ack", 32'(pending_vec[9]), 1);
      strobe_ack(9);
      chk("R8 ack clears pending", 32'(pending_vec[9]), 0);
      chk("R8 no active state", 32'(active_vec[9]), 0);
      strobe_set(9);
      chk("R8 set ignored", 32'(active_vec[9]), 0);

      // R10: set and deactivate same line same cycle
      set_act_valid = 1'b1; set_act_id = 4'd6; deact_valid = 1'b1; deact_id = 4'd6;
      cyc(); clear_strobes();
      chk("R10 set wins", 32'(active_vec[6]), 1);

      // R9: lowest index chosen
      irq_in[3] = 1'b1; irq_in[1] = 1'b1;
      repeat (3) cyc();
      chk("R9 lowest line picked", 32'(sel_id), 1);

      // random phases with fresh configurations
      for (int ph = 0; ph < 3; ph++) begin
         cfg_edge = N'($urandom); cfg_no_active = N'($urandom) & N'($urandom);
         do_reset();
         for (int c = 0; c < 3000; c++) begin
            logic [IDW:0] pk;
            irq_in = irq_in ^ (N'($urandom) & N'($urandom) & N'($urandom));
            pk = lowest(m_pend & ~m_act);
            ack_valid = ($urandom % 3) == 0;
            ack_id = (pk[IDW] && $urandom % 2) ? pk[IDW-1:0] : IDW'($urandom);
            deact_valid = ($urandom % 4) == 0; deact_id = IDW'($urandom);
            set_act_valid = ($urandom % 8) == 0; set_act_id = IDW'($urandom);
            cyc();
         end
         clear_strobes();
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule